// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block drives one low-speed USB packet onto the differential pair and controls the drivers through a separate output enable. When a request is accepted it takes the bus with the line already at idle J. It holds J for one bit period and then sends the sync byte followed by the payload. Every bit is NRZI coded and the stream is bit-stuffed. The packet closes with two bit periods of SE0 and one bit period of J, and after that the drivers are released. The caller gives a byte total that counts the sync byte. The sync byte is generated inside the block, so only the remaining bytes are pulled from the byte input, one strobe per byte.

A second request input sends a bare handshake: sync plus one PID byte, ACK or NAK. No byte is fetched for it. For data packets only, the block raises a one-cycle strobe at the start of the end-of-packet. A device-address register outside the block uses it to load a pending address. Handshakes never raise it, so a new address takes effect only after the data packet that carried the status reply.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset and whenever busy_o is low, oe_o, dp_o, dm_o, pkt_byte_rd_o and addr_commit_o are all low.
- R2: On the clock edge that accepts a request, oe_o rises with the line at J (dp_o=0, dm_o=1). J is held for exactly one bit period before the first sync bit.
- R3: The line codes are J = {dp_o,dm_o} = 2'b01, K = 2'b10 and SE0 = 2'b00. dp_o and dm_o are never high together.
- R4: The first byte on the wire is the sync byte 8'h80. pkt_len_i counts it, and pkt_len_i-1 bytes are fetched through pkt_byte_rd_o. pkt_byte_i is taken in the cycle the strobe is high. Bits are sent LSB first.
- R5: NRZI coding: a 0 bit toggles the line and a 1 bit holds it.
- R6: After six consecutive 1 bits, one extra toggle lasting one bit period is inserted and the run count restarts. This also applies when the sixth 1 is the last bit of the packet.
- R7: End of packet is SE0 for two bit periods, then J for one bit period. The block then drops oe_o and leaves dp_o=dm_o=0.
- R8: hs_start_i sends sync plus one PID byte, 8'hD2 when hs_nak_i=0 and 8'h5A when hs_nak_i=1. No byte is fetched.
- R9: addr_commit_o pulses for one cycle in the first SE0 cycle of a data packet. It never pulses for a handshake.
- R10: busy_o equals oe_o, from acceptance until release. Requests that arrive while busy_o is high are ignored.
- R11: A data request with pkt_len_i=0 is ignored. When both requests arrive in the same cycle, the handshake wins.
- R12: Every line slot (idle J, data bit, stuff bit, SE0, final J) lasts exactly CLK_PER_BIT clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_start_i | input | 1 | Request a data packet |
| pkt_len_i | input | LEN_W | Byte total including sync |
| pkt_byte_i | input | 8 | Next payload byte |
| pkt_byte_rd_o | output | 1 | Payload byte taken this cycle |
| hs_start_i | input | 1 | Request a handshake |
| hs_nak_i | input | 1 | Handshake select: 1 NAK, 0 ACK |
| dp_o | output | 1 | D+ drive level |
| dm_o | output | 1 | D- drive level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Transmission in progress |
| addr_commit_o | output | 1 | Pending device address may be committed |

## Verification
The checker assumes that a payload byte is present on pkt_byte_i in every cycle the fetch strobe is high. It also assumes that no packet holds a run of identical non-SE0 levels longer than the stuffing rule allows, which relies on the block's own stuffing and not on the stimulus. The bench holds pkt_byte_i from a payload array indexed by a counter that advances only after each strobe. It issues each request as a single-cycle pulse, waits for busy_o to fall before the next one, and sends extra requests only to test that they are ignored.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACQ, ST_BITS, ST_EOP0, ST_EOP1, ST_JEND
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam int unsigned RUN_LIMIT = 6;
endpackage

// File: rtl/usb_ls_tx_timer.sv
module usb_ls_tx_timer #(
  parameter int unsigned CLK_PER_BIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usb_ls_tx_stuffer.sv
module usb_ls_tx_stuffer #(
  parameter int unsigned RUN_LIMIT = 6,
  parameter int unsigned RW = $clog2(RUN_LIMIT + 1)
) (
  input  logic          lvl_i,
  input  logic [RW-1:0] run_i,
  input  logic          have_bit_i,
  input  logic          bit_i,
  output logic          lvl_o,
  output logic [RW-1:0] run_o,
  output logic          take_o,
  output logic          done_o
);
  localparam logic [RW-1:0] LIMIT = RW'(RUN_LIMIT);

  always_comb begin
    lvl_o  = lvl_i;
    run_o  = run_i;
    take_o = 1'b0;
    done_o = 1'b0;
    if (run_i == LIMIT) begin
      // forced toggle, no data consumed
      lvl_o = ~lvl_i;
      run_o = '0;
    end else if (have_bit_i) begin
      take_o = 1'b1;
      if (bit_i) begin
        run_o = run_i + 1'b1;
      end else begin
        lvl_o = ~lvl_i;
        run_o = '0;
      end
    end else begin
      done_o = 1'b1;
    end
  end
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 8,
  parameter int unsigned LEN_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_start_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [7:0]       pkt_byte_i,
  output logic             pkt_byte_rd_o,
  input  logic             hs_start_i,
  input  logic             hs_nak_i,
  output logic             dp_o,
  output logic             dm_o,
  output logic             oe_o,
  output logic             busy_o,
  output logic             addr_commit_o
);
  localparam int unsigned RW = $clog2(RUN_LIMIT + 1);

  tx_state_e        state_q;
  logic             lvl_q;      // 1 = J, 0 = K
  logic             se0_q;
  logic             oe_q;
  logic             commit_q;
  logic             is_hs_q;
  logic             have_bit_q;
  logic [7:0]       shreg_q;
  logic [7:0]       pid_q;
  logic [2:0]       bit_idx_q;
  logic [LEN_W-1:0] left_q;
  logic [RW-1:0]    run_q;

  logic             tick;
  logic             st_lvl, st_take, st_done;
  logic [RW-1:0]    st_run;
  logic             in_bits, last_bit, fetch;
  logic [7:0]       next_byte;

  usb_ls_tx_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .tick_o (tick)
  );

  usb_ls_tx_stuffer #(.RUN_LIMIT(RUN_LIMIT), .RW(RW)) u_stuffer (
    .lvl_i      (lvl_q),
    .run_i      (run_q),
    .have_bit_i (have_bit_q),
    .bit_i      (shreg_q[0]),
    .lvl_o      (st_lvl),
    .run_o      (st_run),
    .take_o     (st_take),
    .done_o     (st_done)
  );

  assign in_bits   = (state_q == ST_ACQ) || (state_q == ST_BITS);
  assign last_bit  = (bit_idx_q == 3'd7);
  assign fetch     = in_bits && tick && st_take && last_bit && (left_q != '0);
  assign next_byte = is_hs_q ? pid_q : pkt_byte_i;

  assign pkt_byte_rd_o = fetch && !is_hs_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign oe_o          = oe_q;
  assign dp_o          = oe_q && !se0_q && !lvl_q;
  assign dm_o          = oe_q && !se0_q &&  lvl_q;
  assign addr_commit_o = commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lvl_q      <= 1'b1;
      se0_q      <= 1'b0;
      oe_q       <= 1'b0;
      commit_q   <= 1'b0;
      is_hs_q    <= 1'b0;
      have_bit_q <= 1'b0;
      shreg_q    <= '0;
      pid_q      <= '0;
      bit_idx_q  <= '0;
      left_q     <= '0;
      run_q      <= '0;
    end else begin
      commit_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hs_start_i || (pkt_start_i && pkt_len_i != '0)) begin
            state_q    <= ST_ACQ;
            oe_q       <= 1'b1;
            lvl_q      <= 1'b1;
            se0_q      <= 1'b0;
            shreg_q    <= SYNC_BYTE;
            bit_idx_q  <= '0;
            have_bit_q <= 1'b1;
            run_q      <= '0;
            is_hs_q    <= hs_start_i;
            pid_q      <= hs_nak_i ? PID_NAK : PID_ACK;
            left_q     <= hs_start_i ? LEN_W'(1) : pkt_len_i - 1'b1;
          end
        end
        ST_ACQ, ST_BITS: begin
          if (tick) begin
            if (st_done) begin
              state_q  <= ST_EOP0;
              se0_q    <= 1'b1;
              commit_q <= !is_hs_q;
            end else begin
              state_q <= ST_BITS;
              lvl_q   <= st_lvl;
              run_q   <= st_run;
              if (st_take) begin
                if (last_bit) begin
                  bit_idx_q <= '0;
                  if (left_q != '0) begin
                    shreg_q <= next_byte;
                    left_q  <= left_q - 1'b1;
                  end else begin
                    have_bit_q <= 1'b0;
                  end
                end else begin
                  shreg_q   <= {1'b0, shreg_q[7:1]};
                  bit_idx_q <= bit_idx_q + 1'b1;
                end
              end
            end
          end
        end
        ST_EOP0: if (tick) state_q <= ST_EOP1;
        ST_EOP1: begin
          if (tick) begin
            state_q <= ST_JEND;
            se0_q   <= 1'b0;
            lvl_q   <= 1'b1;
          end
        end
        ST_JEND: begin
          if (tick) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
  parameter int unsigned CLK_PER_BIT = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pkt_byte_rd_o,
  input logic dp_o,
  input logic dm_o,
  input logic oe_o,
  input logic busy_o,
  input logic addr_commit_o
);
  localparam int unsigned MAX_HOLD = 7 * CLK_PER_BIT;

  logic [1:0]  prev_q;
  logic [31:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 2'b00;
      hold_q <= '0;
    end else begin
      prev_q <= {dp_o, dm_o};
      if (oe_o && ({dp_o, dm_o} != 2'b00) && ({dp_o, dm_o} == prev_q))
        hold_q <= (hold_q == 32'hFFFF_FFFF) ? hold_q : hold_q + 1;
      else
        hold_q <= 32'd1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!oe_o && !dp_o && !dm_o && !addr_commit_o && !pkt_byte_rd_o));

  a_r2_acquire_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> (dm_o && !dp_o));

  a_r3_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_o && dm_o));

  a_r4_fetch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_byte_rd_o |-> (busy_o && oe_o));

  a_r6_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= MAX_HOLD);

  a_r9_commit_in_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_commit_o |-> (oe_o && !dp_o && !dm_o));

  a_r9_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_commit_o |=> !addr_commit_o);

  a_r10_busy_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == oe_o);
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.CLK_PER_BIT(CLK_PER_BIT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pkt_byte_rd_o (pkt_byte_rd_o),
  .dp_o          (dp_o),
  .dm_o          (dm_o),
  .oe_o          (oe_o),
  .busy_o        (busy_o),
  .addr_commit_o (addr_commit_o)
);

// File: tb/usb_ls_tx_bench.sv
`timescale 1ns/1ps
module usb_ls_tx_bench;
  localparam int N     = 4;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pkt_start_i = 1'b0;
  logic [LEN_W-1:0] pkt_len_i = '0;
  logic [7:0]       pkt_byte_i;
  logic             pkt_byte_rd_o;
  logic             hs_start_i = 1'b0;
  logic             hs_nak_i = 1'b0;
  logic             dp_o, dm_o, oe_o, busy_o, addr_commit_o;

  always #2.5 clk = ~clk;

  usb_ls_tx #(.CLK_PER_BIT(N), .LEN_W(LEN_W)) u_usb_ls_tx (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .pkt_start_i   (pkt_start_i),
    .pkt_len_i     (pkt_len_i),
    .pkt_byte_i    (pkt_byte_i),
    .pkt_byte_rd_o (pkt_byte_rd_o),
    .hs_start_i    (hs_start_i),
    .hs_nak_i      (hs_nak_i),
    .dp_o          (dp_o),
    .dm_o          (dm_o),
    .oe_o          (oe_o),
    .busy_o        (busy_o),
    .addr_commit_o (addr_commit_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [1:0] exp_q[$];
  logic [7:0] pay [0:15];
  int rd_idx = 0;
  bit rd_seen = 1'b0;
  int rd_cnt = 0;
  int commit_cnt = 0;
  int ph = 0;
  bit oe_prev = 1'b0;
  string cur_req = "R5";
  logic [1:0] got, exp_v;

  assign pkt_byte_i = pay[rd_idx[3:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: one sample per line slot, compared against the scoreboard queue
  always @(negedge clk) begin
    if (oe_o) begin
      if (!oe_prev) ph = 0;
      if (ph == 0) begin
        got = {dp_o, dm_o};
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "extra line slot", int'(got), -1);
        end else begin
          exp_v = exp_q.pop_front();
          check(got == exp_v, cur_req, "line slot {dp,dm}", int'(got), int'(exp_v));
        end
      end
      ph = (ph + 1) % N;
    end
    if (addr_commit_o) commit_cnt++;
    if (rd_seen) rd_idx++;
    rd_seen = pkt_byte_rd_o;
    if (pkt_byte_rd_o) rd_cnt++;
    oe_prev = oe_o;
  end

  task automatic push_lvl(input logic lvl);
    exp_q.push_back(lvl ? 2'b01 : 2'b10);
  endtask

  // expected wire image from the line rules alone
  task automatic build(input int nb, input bit hs, input logic [7:0] pid);
    logic lvl = 1'b1;
    int ones = 0;
    logic [7:0] cur;
    exp_q.push_back(2'b01);
    for (int i = 0; i < nb; i++) begin
      cur = (i == 0) ? 8'h80 : (hs ? pid : pay[i-1]);
      for (int k = 0; k < 8; k++) begin
        if (cur[k]) ones++;
        else begin lvl = ~lvl; ones = 0; end
        push_lvl(lvl);
        if (ones == 6) begin lvl = ~lvl; ones = 0; push_lvl(lvl); end
      end
    end
    exp_q.push_back(2'b00);
    exp_q.push_back(2'b00);
    exp_q.push_back(2'b01);
  endtask

  task automatic run_pkt(input int len, input bit hs, input bit nak,
                         input string req, input bit both, input bit extra);
    int slots, cyc;
    exp_q.delete();
    rd_idx = 0; rd_cnt = 0; commit_cnt = 0;
    build(hs ? 2 : len, hs, nak ? 8'h5A : 8'hD2);
    slots = exp_q.size();
    cur_req = req;
    @(negedge clk);
    if (hs || both) begin hs_start_i = 1'b1; hs_nak_i = nak; end
    if (!hs || both) begin pkt_start_i = 1'b1; pkt_len_i = LEN_W'(len); end
    @(negedge clk);
    hs_start_i = 1'b0; pkt_start_i = 1'b0;
    check(busy_o == 1'b1, "R10", "busy after accept", int'(busy_o), 1);
    check({oe_o, dp_o, dm_o} == 3'b101, "R2", "acquire at J", int'({oe_o, dp_o, dm_o}), 5);
    cyc = 0;
    while (busy_o && cyc < 20000) begin
      if (extra && cyc == 3 * N) begin
        pkt_start_i = 1'b1; pkt_len_i = 8'd5; hs_start_i = 1'b1;
      end
      if (extra && cyc == 3 * N + 1) begin
        pkt_start_i = 1'b0; hs_start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    check(cyc == slots * N, "R12", "busy cycles", cyc, slots * N);
    check(exp_q.size() == 0, "R7", "slots left unsent", exp_q.size(), 0);
    check({oe_o, dp_o, dm_o} == 3'b000, "R7", "released", int'({oe_o, dp_o, dm_o}), 0);
    check(commit_cnt == (hs ? 0 : 1), "R9", "commit pulses", commit_cnt, hs ? 0 : 1);
    check(rd_cnt == (hs ? 0 : len - 1), hs ? "R8" : "R4", "byte fetches", rd_cnt, hs ? 0 : len - 1);
    if (extra) begin
      repeat (4 * N) @(negedge clk);
      check(oe_o == 1'b0 && busy_o == 1'b0, "R10", "request while busy ignored",
            int'(busy_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({oe_o, dp_o, dm_o, busy_o, addr_commit_o, pkt_byte_rd_o} == 6'b0,
          "R1", "reset outputs", int'({oe_o, dp_o, dm_o, busy_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(oe_o == 1'b0 && busy_o == 1'b0, "R1", "idle after reset", int'(oe_o), 0);

    pay[0] = 8'h2D; pay[1] = 8'hA5;
    run_pkt(3, 1'b0, 1'b0, "R5", 1'b0, 1'b0);

    pay[0] = 8'h00; pay[1] = 8'h00;
    run_pkt(3, 1'b0, 1'b0, "R5", 1'b0, 1'b0);

    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'hFF;
    run_pkt(4, 1'b0, 1'b0, "R6", 1'b0, 1'b0);

    pay[0] = 8'hFC;  // six ones end the packet: stuff before EOP
    run_pkt(2, 1'b0, 1'b0, "R6", 1'b0, 1'b0);

    run_pkt(1, 1'b0, 1'b0, "R4", 1'b0, 1'b0);  // sync only

    run_pkt(2, 1'b1, 1'b0, "R8", 1'b0, 1'b0);  // ACK
    run_pkt(2, 1'b1, 1'b1, "R8", 1'b0, 1'b0);  // NAK

    pay[0] = 8'h3C; pay[1] = 8'h81;
    run_pkt(3, 1'b0, 1'b0, "R10", 1'b0, 1'b1);

    run_pkt(2, 1'b1, 1'b0, "R11", 1'b1, 1'b0); // both requests: handshake wins

    @(negedge clk);
    pkt_start_i = 1'b1; pkt_len_i = '0;
    @(negedge clk);
    pkt_start_i = 1'b0;
    repeat (2 * N) @(negedge clk);
    check(busy_o == 1'b0 && oe_o == 1'b0, "R11", "zero length ignored", int'(busy_o), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule